// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

After a reset, a slave on a two-wire serial bus can still be in the middle of sending a byte. It may hold SDA low, and then the master cannot form a START condition. This block runs on the master side as soon as reset is released. It pulls SCL low and releases it a limited number of times, and it watches SDA during each high phase. Once SDA reads high, or the last allowed pulse has been given, it stops clocking and leaves SCL released. The slave is expected to let go of SDA in the acknowledge slot that follows its byte.

With SCL parked high, the sequencer waits for a start request. When the request comes, it pulls SDA low while SCL stays high. That START makes every slave drop whatever command it had in progress and wait for an address. After SDA has been low for one phase length, the block raises its done flag and clears busy. A request that arrives while pulsing is still running is remembered and served when the park phase is reached.

Both lines are open-drain. The block has only pull enables and never drives a line high. One input sets the phase length in system clocks, and a count output reports how many pulses the recovery used.

Top module: `bus_unstick_seq`

## Requirements
- R1: While reset is asserted, SCL is pulled low, SDA is released, busy is 1, done is 0 and the pulse count is 0.
- R2: Every SCL low phase lasts exactly half_div_i + 1 system clocks.
- R3: A high phase times half_div_i + 1 clocks, counted only while the line level seen through a two-flop synchronizer is high. An unstretched high phase therefore lasts half_div_i + 3 clocks, and each clock that SCL is held low externally adds one clock.
- R4: SDA is sampled through a two-flop synchronizer at timer value half_div_i / 2 of each high phase. A high sample ends pulsing at once, with SCL left released, and pulses_o equals the number of SCL release events.
- R5: No more than 9 pulses are given. At the sampling point of the 9th pulse the block parks whatever SDA reads.
- R6: While parked with no request, SCL and SDA are both released, busy is 1 and done is 0, for as long as no request arrives.
- R7: On a request in the park phase, SDA is pulled low with SCL released. done_o rises exactly half_div_i + 1 clocks after the SDA pull starts, busy_o falls with it, and SDA stays pulled. SDA is never pulled while SCL is pulled.
- R8: A start_req_i pulse given during pulsing is held. The START follows the park phase with no further request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req_i | input | 1 | Request to issue a START; may come at any time |
| half_div_i | input | DIV_W | Phase length minus one, in system clocks |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | High from reset until the START completes |
| done_o | output | 1 | START issued, bus ready |
| pulses_o | output | CNT_W | Number of SCL pulses used |

## Verification
A bus model lets a slave hold SDA low until it has seen a chosen number of pulses. That number is set to zero, to mid values and to values at and beyond the limit. These runs separate the early exit (count equal to release point plus one) from the cap at nine, with a slave that never lets go. Some patterns also stretch the first high phase, which shows that the high timer waits for the line level and not for the drive. Other patterns send the start request early rather than after parking, which separates a latched request from one that was dropped. A reset in mid-run checks that the sequence starts over from its reset state.

// File: rtl/unstick_pkg.sv
package unstick_pkg;
  typedef enum logic [2:0] {
    ST_LOW,
    ST_HIGH,
    ST_PARK,
    ST_START,
    ST_DONE
  } unstick_st_e;
endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb sh_d = {sh_q[STAGES-2:0], d_i[b]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    assign q_o[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/unstick_phase_timer.sv
module unstick_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] limit_i,
  output logic             at_mid_o,
  output logic             at_end_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  assign at_end_o = en_i && (cnt_q == limit_i);
  assign at_mid_o = en_i && (cnt_q == (limit_i >> 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)         cnt_d = '0;
    else if (at_end_o) cnt_d = '0;
    else if (en_i)     cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(limit_i) |-> cnt_q <= limit_i);
endmodule

// File: rtl/bus_unstick_seq.sv
module bus_unstick_seq
  import unstick_pkg::*;
#(
  parameter  int DIV_W      = 8,
  parameter  int MAX_PULSES = 9,
  localparam int CNT_W      = $clog2(MAX_PULSES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_pull_o,
  output logic             sda_pull_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] pulses_o
);
  unstick_st_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic [1:0]       line_s;
  logic             scl_s, sda_s;
  logic             ph_en, ph_clr, ph_mid, ph_end;
  logic             last_pulse;

  unstick_sync #(.W(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  // timer clock enable: low and START phases always run, high waits for the line
  assign ph_en  = (st_q == ST_LOW) || (st_q == ST_START) ||
                  ((st_q == ST_HIGH) && scl_s);
  assign ph_clr = (st_d != st_q);

  unstick_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (ph_clr),
    .en_i     (ph_en),
    .limit_i  (half_div_i),
    .at_mid_o (ph_mid),
    .at_end_o (ph_end)
  );

  assign last_pulse = (cnt_q == CNT_W'(MAX_PULSES));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    req_d = req_q | start_req_i;
    unique case (st_q)
      ST_LOW: begin
        if (ph_end) begin
          st_d  = ST_HIGH;
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_HIGH: begin
        if (ph_mid && (sda_s || last_pulse)) st_d = ST_PARK;
        else if (ph_end)                     st_d = ST_LOW;
      end
      ST_PARK: begin
        if (req_q) st_d = ST_START;
      end
      ST_START: begin
        if (ph_end) st_d = ST_DONE;
      end
      default: st_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_LOW;
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign scl_pull_o = (st_q == ST_LOW);
  assign sda_pull_o = (st_q == ST_START) || (st_q == ST_DONE);
  assign busy_o     = (st_q != ST_DONE);
  assign done_o     = (st_q == ST_DONE);
  assign pulses_o   = cnt_q;

  // R5
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_PULSES));

  // R4
  count_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> $fell(scl_pull_o));

  // R6
  park_scl_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PARK) |=> !scl_pull_o);

  // R7
  start_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !$past(scl_pull_o));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o && sda_pull_o && !busy_o);
endmodule

// File: tb/bus_unstick_seq_tb.sv
`timescale 1ns/1ps
module bus_unstick_seq_tb;
  localparam int DIV_W = 8;
  localparam int CNT_W = 4;
  localparam int NV    = 7;
  // columns: half_div, slave release after N pulses, stretch clocks, early request
  localparam int VEC [NV][4] = '{
    '{3, 0,  0, 0},
    '{3, 2,  0, 0},
    '{5, 7,  2, 0},
    '{2, 8,  0, 0},
    '{4, 12, 3, 0},
    '{3, 3,  0, 1},
    '{1, 4,  1, 1}
  };

  bit               clk;
  logic             rst_n;
  logic             start_req;
  logic [DIV_W-1:0] half_div;
  logic             scl_i, sda_i;
  logic             scl_pull, sda_pull, busy, done;
  logic [CNT_W-1:0] pulses;

  int  n_chk, n_err;
  int  cur_div, cur_rel, cur_stretch;
  int  low_bad, high_bad, overlap_bad, pulses_done, highs_started;
  int  low_run, high_run, sda_run;
  bit  stretch, prev_pull, finished;

  always #4 clk = ~clk;

  assign scl_i = !scl_pull && !stretch;
  assign sda_i = !sda_pull && !(pulses_done < cur_rel);

  bus_unstick_seq #(.DIV_W(DIV_W), .MAX_PULSES(9)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req_i (start_req),
    .half_div_i  (half_div),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .scl_pull_o  (scl_pull),
    .sda_pull_o  (sda_pull),
    .busy_o      (busy),
    .done_o      (done),
    .pulses_o    (pulses)
  );

  // bus monitor and slave model, on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      low_bad = 0; high_bad = 0; overlap_bad = 0; pulses_done = 0;
      highs_started = 0; low_run = 0; high_run = 0; sda_run = 0;
      prev_pull = 1'b1; stretch = (cur_stretch > 0);
    end else begin
      if (scl_pull) begin
        if (!prev_pull) begin
          pulses_done++;
          if (high_run != cur_div + 3 + ((pulses_done == 1) ? cur_stretch : 0)) high_bad++;
          high_run = 0;
          low_run  = 0;
        end
        low_run++;
      end else begin
        if (prev_pull) begin
          if (highs_started > 0 && low_run != cur_div + 1) low_bad++;
          highs_started++;
          high_run = 0;
        end
        high_run++;
        if (stretch && highs_started == 1 && high_run == cur_stretch + 1) stretch = 1'b0;
      end
      if (scl_pull && sda_pull) overlap_bad++;
      if (sda_pull && !done) sda_run++;
      prev_pull = scl_pull;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int div, input int rel, input int st, input int early);
    int exp_p;
    exp_p = (rel + 1 > 9) ? 9 : rel + 1;
    @(negedge clk);
    rst_n = 1'b0; start_req = 1'b0;
    cur_div = div; cur_rel = rel; cur_stretch = st; half_div = DIV_W'(div);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    if (early != 0) begin
      @(negedge clk); start_req = 1'b1;
      @(negedge clk); start_req = 1'b0;
    end
    repeat (250) @(negedge clk);
    if (rel >= 8) chk(int'(pulses) == exp_p, "R5 pulse count", int'(pulses), exp_p);
    else          chk(int'(pulses) == exp_p, "R4 pulse count", int'(pulses), exp_p);
    chk(highs_started == exp_p, "R4 release events", highs_started, exp_p);
    chk(low_bad == 0, "R2 low phase length", low_bad, 0);
    chk(high_bad == 0, "R3 high phase length", high_bad, 0);
    if (early == 0) begin
      chk(!scl_pull && !sda_pull && busy && !done, "R6 park state",
          {scl_pull, sda_pull, busy, done}, 4'b0010);
      start_req = 1'b1;
      @(negedge clk); start_req = 1'b0;
      repeat (div + 10) @(negedge clk);
      chk(done && !busy, "R7 done after start", {done, busy}, 2'b10);
    end else begin
      chk(done && !busy, "R8 held request served", {done, busy}, 2'b10);
    end
    chk(sda_run == div + 1, "R7 sda low before done", sda_run, div + 1);
    chk(sda_pull && !scl_pull, "R7 lines after start", {sda_pull, scl_pull}, 2'b10);
    chk(overlap_bad == 0, "R7 sda pulled with scl low", overlap_bad, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_req = 1'b0; half_div = DIV_W'(3);
    cur_div = 3; cur_rel = 0; cur_stretch = 0;
    repeat (2) @(negedge clk);
    chk(scl_pull && !sda_pull && busy && !done && pulses == 0, "R1 reset state",
        {scl_pull, sda_pull, busy, done}, 4'b1010);

    for (int i = 0; i < NV; i++) run_case(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);

    // reset in the middle of pulsing starts the sequence over
    @(negedge clk);
    rst_n = 1'b0; cur_div = 4; cur_rel = 20; cur_stretch = 0; half_div = DIV_W'(4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(scl_pull && !sda_pull && busy && !done && pulses == 0, "R1 mid-run reset",
        {scl_pull, sda_pull, busy, done}, 4'b1010);
    rst_n = 1'b1;
    repeat (250) @(negedge clk);
    chk(pulses == 9 && !done && busy, "R5 cap after restart", int'(pulses), 9);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule